// File: doc/BRIEF.md
# Two-Button Up/Down Hex Digit Counter

This block keeps a four-bit count that two push buttons move up and down, and it shows that count as one hexadecimal digit on a seven-segment display. Both buttons are active low. Everything runs on one free-running system clock. Each raw button line passes through a two-stage synchronizer. A press is then found by comparing the synchronized level with its value from the cycle before. The counter register changes only on that clock, so neither button ever acts as a clock or as an asynchronous control.

The count wraps modulo 16 in both directions. A press pulse from both buttons in the same cycle cancels out. A release never moves the count, and a button that is held down counts once. Mechanical bounce is not filtered: the buttons are expected to arrive already clean.

Top module: `updown_hex_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 and `seg_n_o` shows 7'h40. Both stored button histories are set to released.
- R2: A high-to-low transition on `key_up_n` raises the count by one. The new count is visible after the third rising edge that follows the transition.
- R3: A high-to-low transition on `key_dn_n` lowers the count by one, with the same latency as R2.
- R4: A button held low for any number of cycles changes the count only once.
- R5: A low-to-high transition (release) on either button never changes the count.
- R6: If both buttons are pressed in the same cycle, the count stays unchanged.
- R7: Raising from 15 gives 0.
- R8: Lowering from 0 gives 15.
- R9: `seg_n_o` is active low, with bit 6 = g down to bit 0 = a. The active-high patterns for digits 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. `seg_n_o` is the bitwise inverse of the pattern for the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| key_up_n | input | 1 | Raw increment button, low when pressed |
| key_dn_n | input | 1 | Raw decrement button, low when pressed |
| count_o | output | 4 | Current count |
| seg_n_o | output | 7 | Active-low segments g..a for the count |

## Verification
Single presses of each button separate increment from decrement and fix the three-edge latency. A long hold followed by a release shows that only falling edges count, which rules out both level-triggered and release-triggered updates. Simultaneous presses, together with presses spaced a few cycles apart, separate the cancel rule from ordinary sequencing. Counting up through all sixteen values and then down across zero covers both wrap points and every segment pattern.

// File: rtl/updown_pkg.sv
package updown_pkg;
  localparam int CNT_W = 4;
  localparam int SEG_W = 7;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic up, input logic dn);
    logic [CNT_W-1:0] nxt;
    nxt = cur;
    if (up && !dn) nxt = cur + CNT_W'(1);
    else if (dn && !up) nxt = cur - CNT_W'(1);
    return nxt;
  endfunction

  // active-high gfedcba pattern, bit 6 = g
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/key_press_detect.sv
module key_press_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic key_n,
  output logic press_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], key_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_now = sync_q[SYNC_STAGES-1];
  assign press_o   = prev_q & ~level_now;

  // R4: a held key yields a single pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);
  // R5: no pulse on a rising (release) edge
  a_r5_release_silent: assert property (@(posedge clk) disable iff (rst)
    (level_now && !$past(level_now)) |-> !press_o);
endmodule

// File: rtl/count_core.sv
module count_core
  import updown_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= step_count(count_o, up_i, dn_i);
  end

  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (up_i && !dn_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));
  a_r3_dn_step: assert property (@(posedge clk) disable iff (rst)
    (dn_i && !up_i) |=> count_o == CNT_W'($past(count_o) - 1'b1));
  a_r6_both_cancel: assert property (@(posedge clk) disable iff (rst)
    (dn_i && up_i) |=> $stable(count_o));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!dn_i && !up_i) |=> $stable(count_o));
endmodule

// File: rtl/hex_seg_decode.sv
module hex_seg_decode
  import updown_pkg::*;
(
  input  logic [CNT_W-1:0] value_i,
  output logic [SEG_W-1:0] seg_n_o
);
  always_comb seg_n_o = ~hex_glyph(value_i);
endmodule

// File: rtl/updown_hex_counter.sv
module updown_hex_counter
  import updown_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_up_n,
  input  logic             key_dn_n,
  output logic [CNT_W-1:0] count_o,
  output logic [SEG_W-1:0] seg_n_o
);
  localparam int NKEYS = 2;
  logic [NKEYS-1:0] key_raw_n;
  logic [NKEYS-1:0] press;
  logic             up_press, dn_press;

  assign key_raw_n = {key_dn_n, key_up_n};

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    key_press_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst(rst), .key_n(key_raw_n[k]), .press_o(press[k]));
  end

  assign up_press = press[0];
  assign dn_press = press[1];

  count_core u_cnt (
    .clk(clk), .rst(rst), .up_i(up_press), .dn_i(dn_press), .count_o(count_o));

  hex_seg_decode u_seg (.value_i(count_o), .seg_n_o(seg_n_o));

  // R9: every hex glyph lights at least two segments
  a_r9_glyph_lit: assert property (@(posedge clk) disable iff (rst)
    $countones(~seg_n_o) >= 2);
  // R1: the cycle after reset shows zero
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (count_o == '0));
endmodule

// File: tb/updown_hex_counter_tb.sv
`timescale 1ns/1ps
module updown_hex_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_up_n = 1'b1;
  logic key_dn_n = 1'b1;
  logic [3:0] count_o;
  logic [6:0] seg_n_o;
  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  logic [3:0] model = 4'd0;

  always #2.5 clk = ~clk;

  updown_hex_counter u_dut (.clk(clk), .rst(rst), .key_up_n(key_up_n),
    .key_dn_n(key_dn_n), .count_o(count_o), .seg_n_o(seg_n_o));

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F;
      4: on = 7'h66; 5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07;
      8: on = 7'h7F; 9: on = 7'h6F; 10: on = 7'h77; 11: on = 7'h7C;
      12: on = 7'h39; 13: on = 7'h5E; 14: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // lower the chosen keys, check after latency, release, check again
  task automatic press(input bit up, input bit dn, input string req);
    @(negedge clk);
    if (up) key_up_n = 1'b0;
    if (dn) key_dn_n = 1'b0;
    wait_neg(2);
    check({req, " before latency"}, count_o, model);
    wait_neg(1);
    if (up && !dn) model = model + 4'd1;
    if (dn && !up) model = model - 4'd1;
    check(req, count_o, model);
    key_up_n = 1'b1;
    key_dn_n = 1'b1;
    wait_neg(4);
    check({req, " after release R5"}, count_o, model);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wait_neg(3);
    rst = 1'b0;
    model = 4'd0;
    check("R1 count", count_o, 0);
    check("R1 seg", seg_n_o, 7'h40);
  endtask

  task automatic t_up_down();
    press(1, 0, "R2 up");
    press(1, 0, "R2 up second");
    press(0, 1, "R3 down");
  endtask

  task automatic t_hold();
    @(negedge clk);
    key_dn_n = 1'b0;
    wait_neg(3);
    model = model - 4'd1;
    check("R4 first step", count_o, model);
    wait_neg(20);
    check("R4 held", count_o, model);
    key_dn_n = 1'b1;
    wait_neg(6);
    check("R5 release", count_o, model);
  endtask

  task automatic t_both();
    press(1, 1, "R6 both");
    // staggered presses still both count
    @(negedge clk);
    key_up_n = 1'b0;
    wait_neg(2);
    key_dn_n = 1'b0;
    wait_neg(1);
    check("R6 staggered up", count_o, model + 4'd1);
    wait_neg(2);
    check("R6 staggered down", count_o, model);
    key_up_n = 1'b1;
    key_dn_n = 1'b1;
    wait_neg(4);
  endtask

  task automatic t_wrap_sweep();
    t_reset();
    for (int i = 0; i < 16; i++) begin
      check("R9 seg", seg_n_o, exp_seg(model));
      press(1, 0, "R7 sweep up");
    end
    check("R7 wrap to 0", count_o, 0);
    press(0, 1, "R8 wrap down");
    check("R8 value 15", count_o, 15);
    check("R9 seg F", seg_n_o, exp_seg(4'hF));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_up_down();
    t_hold();
    t_both();
    t_wrap_sweep();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule